// File: doc/BRIEF.md
# Dual-Half Interval Timer

This block is a memory-mapped timer built from two independent up-counters of `CNT_W` bits each, called the lower half and the upper half. Both count on the block clock. Each half has its own count register, its own period register and its own interrupt line. A shared control word holds a two-bit run-mode field for each half. A global control word releases each half from reset and selects the counting arrangement.

A half that is released and enabled counts up by one every cycle. When its count equals its period, the half pulses its interrupt. In repeat mode the half then reloads to zero and keeps running. In single mode it returns to zero and clears its own mode field, which software can see on a read. With the period at all ones, a repeat-mode half becomes a free-running counter that software can sample at any time.

The lower half can also carry a compare register. Writing that register arms a single event, which fires when the running count equals the written value. Software schedules an event by reading the count and writing back the count plus a delta.

Top module: `dual_half_timer`

## Requirements
- R1: After reset, every register reads zero except the two period registers, which read all ones, and both interrupt outputs are low.
- R2: Global control bit 0 releases the lower half and bit 1 releases the upper half. A half whose release bit is 0 holds its count at zero, does not count and raises no event.
- R3: A half counts only when global control bits [3:2] equal 01. Any other value freezes both counts. Global control bits [3:0] read back as written.
- R4: A released and enabled half increments by one per clock cycle. A write to its count register (0x10 lower, 0x14 upper) loads the written value, and that write takes priority over counting in the same cycle.
- R5: When an enabled half's count equals its period (0x18 lower, 0x1C upper), its interrupt is high for the one cycle after that clock edge. In repeat mode (field 10) the count reloads to zero, so events recur every period+1 cycles. A period of zero gives an event on every cycle.
- R6: In single mode (field 01), the event also clears the half's field to 00. The count then stays at zero and no further event occurs.
- R7: The control register at 0x20 holds the lower field at bits [7:6] and the upper field at bits [23:22], with the encoding 00 off, 01 single and 10 repeat. A written 11 is stored as 00. Reads return the live fields, and all other bits read as zero.
- R8: A control write that leaves one half's field unchanged does not disturb that half's counting.
- R9: A control write of zero stops both halves, and their counts hold their values.
- R10: A repeat-mode half with its period at all ones steps from all ones to zero, raising an event at the wrap, and keeps counting.
- R11: A write to the compare register (0x60, lower half) arms one event. The lower interrupt pulses in the cycle after the edge at which the running lower count equals the written value, and then the compare disarms.
- R12: Writes to unmapped offsets change nothing, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the count tick |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte offset of the register accessed |
| wdata_i | input | CNT_W | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | CNT_W | Registered read data for the offset presented in the previous cycle |
| irq_lo_o | output | 1 | Lower-half event pulse (period match or compare match) |
| irq_hi_o | output | 1 | Upper-half event pulse (period match) |

## Verification
The period-match path is driven from a table of period and mode pairs: a zero period, a short single-mode period and longer repeat-mode periods. The measured cycle distance from enable to event tells an off-by-one in reload apart from a missing reload, and the second gap tells repeat mode apart from single mode. Directed tests then load counts near all ones to observe the wrap, and sample the upper count across lower-half control writes to show that the two halves are independent. The compare path is tried with a delta taken from a live count read, so a match against the wrong count or a repeated firing shows up as a wrong or extra pulse. Reset release, the timer-mode field, the illegal field value 11 and unmapped offsets are each probed through read-back.

// File: rtl/dht_pkg.sv
package dht_pkg;
  typedef enum logic [1:0] {
    EN_OFF  = 2'b00,
    EN_ONCE = 2'b01,
    EN_LOOP = 2'b10
  } en_mode_e;

  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_CTRL   = 8'h20;
  localparam logic [7:0] OFS_GCTRL  = 8'h24;

  localparam int LO_FIELD_SH = 6;
  localparam int HI_FIELD_SH = 22;

  function automatic en_mode_e decode_mode(input logic [1:0] f);
    case (f)
      2'b01:   return EN_ONCE;
      2'b10:   return EN_LOOP;
      default: return EN_OFF;
    endcase
  endfunction
endpackage

// File: rtl/dht_half.sv
module dht_half
  import dht_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rel_i,
  input  logic         unchained_i,
  input  logic         mode_we_i,
  input  logic [1:0]   mode_wd_i,
  input  logic         cnt_we_i,
  input  logic         prd_we_i,
  input  logic [W-1:0] wd_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] prd_o,
  output logic [1:0]   mode_o,
  output logic         run_o,
  output logic         hit_o
);
  en_mode_e     mode_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] prd_q;
  logic         run;
  logic         hit;

  assign run = rel_i && unchained_i && (mode_q != EN_OFF);
  assign hit = run && !cnt_we_i && (cnt_q == prd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= EN_OFF;
      cnt_q  <= '0;
      prd_q  <= '1;
    end else begin
      if (prd_we_i) prd_q <= wd_i;

      if (!rel_i)        cnt_q <= '0;
      else if (cnt_we_i) cnt_q <= wd_i;
      else if (hit)      cnt_q <= '0;
      else if (run)      cnt_q <= cnt_q + 1'b1;

      if (mode_we_i)                      mode_q <= decode_mode(mode_wd_i);
      else if (hit && mode_q == EN_ONCE)  mode_q <= EN_OFF;
    end
  end

  assign cnt_o  = cnt_q;
  assign prd_o  = prd_q;
  assign mode_o = mode_q;
  assign run_o  = run;
  assign hit_o  = hit;

  // R2: an unreleased half sits at zero
  assert_held_R2: assert property (@(posedge clk) disable iff (rst)
    !rel_i |=> (cnt_q == '0));

  // R4: one step per cycle while running below the period
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (rel_i && unchained_i && mode_q != EN_OFF && !cnt_we_i && cnt_q != prd_q)
      |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R5: a period match reloads the count to zero
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    (rel_i && unchained_i && mode_q != EN_OFF && !cnt_we_i && cnt_q == prd_q)
      |=> (cnt_q == '0));

  // R6: single mode turns itself off at the match
  assert_oneshot_R6: assert property (@(posedge clk) disable iff (rst)
    (rel_i && unchained_i && mode_q == EN_ONCE && !cnt_we_i && !mode_we_i
     && cnt_q == prd_q) |=> (mode_q == EN_OFF));
endmodule

// File: rtl/dht_cmp.sv
module dht_cmp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wd_i,
  input  logic [W-1:0] cnt_i,
  input  logic         run_i,
  output logic [W-1:0] val_o,
  output logic         hit_o
);
  logic [W-1:0] val_q;
  logic         armed_q;
  logic         hit;

  assign hit = armed_q && run_i && (cnt_i == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q   <= '0;
      armed_q <= 1'b0;
    end else if (we_i) begin
      val_q   <= wd_i;
      armed_q <= 1'b1;
    end else if (hit) begin
      armed_q <= 1'b0;
    end
  end

  assign val_o = val_q;
  assign hit_o = hit;

  // R11: a compare match fires once and disarms
  assert_cmp_once_R11: assert property (@(posedge clk) disable iff (rst)
    (hit && !we_i) |=> !armed_q);
endmodule

// File: rtl/dual_half_timer.sv
module dual_half_timer
  import dht_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          CNT_W   = 32,
  parameter bit          HAS_CMP = 1'b1,
  parameter logic [7:0]  CMP_OFS = 8'h60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  localparam int NUM_HALF = 2;

  logic [3:0]       gctrl_q;
  logic             unchained;
  logic [CNT_W-1:0] cnt   [NUM_HALF];
  logic [CNT_W-1:0] prd   [NUM_HALF];
  logic [1:0]       mode  [NUM_HALF];
  logic [NUM_HALF-1:0] run;
  logic [NUM_HALF-1:0] hit;
  logic             ctrl_we;
  logic             cmp_hit;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] rd_n;
  logic             mapped;
  logic [CNT_W-1:0] rdata_q;
  logic             irq_lo_q;
  logic             irq_hi_q;

  assign unchained = (gctrl_q[3:2] == 2'b01);
  assign ctrl_we   = we_i && (addr_i == ADDR_W'(OFS_CTRL));

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam logic [7:0] CNT_OFS = (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
    localparam logic [7:0] PRD_OFS = (h == 0) ? OFS_PRD_LO : OFS_PRD_HI;
    localparam int         SH      = (h == 0) ? LO_FIELD_SH : HI_FIELD_SH;

    dht_half #(.W(CNT_W)) u_half (
      .clk         (clk),
      .rst         (rst),
      .rel_i       (gctrl_q[h]),
      .unchained_i (unchained),
      .mode_we_i   (ctrl_we),
      .mode_wd_i   (wdata_i[SH +: 2]),
      .cnt_we_i    (we_i && (addr_i == ADDR_W'(CNT_OFS))),
      .prd_we_i    (we_i && (addr_i == ADDR_W'(PRD_OFS))),
      .wd_i        (wdata_i),
      .cnt_o       (cnt[h]),
      .prd_o       (prd[h]),
      .mode_o      (mode[h]),
      .run_o       (run[h]),
      .hit_o       (hit[h])
    );
  end

  if (HAS_CMP) begin : g_cmp
    dht_cmp #(.W(CNT_W)) u_cmp (
      .clk   (clk),
      .rst   (rst),
      .we_i  (we_i && (addr_i == ADDR_W'(CMP_OFS))),
      .wd_i  (wdata_i),
      .cnt_i (cnt[0]),
      .run_i (run[0]),
      .val_o (cmp_val),
      .hit_o (cmp_hit)
    );
  end else begin : g_nocmp
    assign cmp_val = '0;
    assign cmp_hit = 1'b0;
  end

  always_comb begin
    rd_n   = '0;
    mapped = 1'b1;
    if      (addr_i == ADDR_W'(OFS_CNT_LO)) rd_n = cnt[0];
    else if (addr_i == ADDR_W'(OFS_CNT_HI)) rd_n = cnt[1];
    else if (addr_i == ADDR_W'(OFS_PRD_LO)) rd_n = prd[0];
    else if (addr_i == ADDR_W'(OFS_PRD_HI)) rd_n = prd[1];
    else if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rd_n[LO_FIELD_SH +: 2] = mode[0];
      rd_n[HI_FIELD_SH +: 2] = mode[1];
    end
    else if (addr_i == ADDR_W'(OFS_GCTRL)) rd_n[3:0] = gctrl_q;
    else if (HAS_CMP && addr_i == ADDR_W'(CMP_OFS)) rd_n = cmp_val;
    else mapped = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gctrl_q  <= '0;
      rdata_q  <= '0;
      irq_lo_q <= 1'b0;
      irq_hi_q <= 1'b0;
    end else begin
      if (we_i && addr_i == ADDR_W'(OFS_GCTRL)) gctrl_q <= wdata_i[3:0];
      rdata_q  <= rd_n;
      irq_lo_q <= hit[0] || cmp_hit;
      irq_hi_q <= hit[1];
    end
  end

  assign rdata_o  = rdata_q;
  assign irq_lo_o = irq_lo_q;
  assign irq_hi_o = irq_hi_q;

  // R12: unmapped offsets read back as zero
  assert_unmapped_R12: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (rdata_o == '0));

  // R5: the upper interrupt follows an upper period match
  assert_irq_hi_R5: assert property (@(posedge clk) disable iff (rst)
    (gctrl_q[1] && unchained && mode[1] != 2'b00 && cnt[1] == prd[1]
     && !(we_i && addr_i == ADDR_W'(OFS_CNT_HI))) |=> irq_hi_o);
endmodule

// File: tb/tb_dual_half_timer.sv
module tb_dual_half_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq_lo, irq_hi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_half_timer dut (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .irq_lo_o(irq_lo), .irq_hi_o(irq_hi)
  );

  // table: run mode, period, expected enable-to-event cycles
  localparam int NV = 5;
  localparam logic [1:0]  V_MODE [NV] = '{2'b10, 2'b01, 2'b10, 2'b01, 2'b10};
  localparam logic [31:0] V_PRD  [NV] = '{32'd0, 32'd0, 32'd3, 32'd7, 32'd12};
  localparam int          V_EXP  [NV] = '{1, 1, 4, 8, 13};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic wait_irq(input bit hi, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!(hi ? irq_hi : irq_lo) && n < 1000);
  endtask

  task automatic quiet(input bit hi, input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (hi ? irq_hi : irq_lo) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d, a, b;
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(8'h20, d); chk("R1 ctrl", d, 0);
    rd(8'h24, d); chk("R1 gctrl", d, 0);
    rd(8'h10, d); chk("R1 cnt_lo", d, 0);
    rd(8'h18, d); chk("R1 prd_lo", d, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R1 prd_hi", d, 32'hFFFF_FFFF);
    chk("R1 irqs", {irq_hi, irq_lo}, 0);

    // R2: enabled but unreleased half stays at zero
    wr(8'h18, 5);
    wr(8'h20, 32'h80);
    quiet(0, 12, "R2 no event");
    rd(8'h10, d); chk("R2 held", d, 0);

    // R3: released but timer-mode field 00 -> frozen
    wr(8'h24, 32'h3);
    quiet(0, 12, "R3 no event");
    rd(8'h10, d); chk("R3 frozen", d, 0);
    wr(8'h20, 0);
    wr(8'h24, 32'h7);
    rd(8'h24, d); chk("R3 gctrl readback", d, 7);

    // R5/R6 table walk
    for (int v = 0; v < NV; v++) begin
      wr(8'h20, 0);
      wr(8'h10, 0);
      wr(8'h18, V_PRD[v]);
      wr(8'h20, 32'(V_MODE[v]) << 6);
      wait_irq(0, n);
      chk("R5 first event gap", n, V_EXP[v]);
      if (V_MODE[v] == 2'b01) begin
        rd(8'h20, d); chk("R6 field cleared", d, 0);
        quiet(0, 2 * V_EXP[v] + 10, "R6 no repeat");
        rd(8'h10, d); chk("R6 count stays zero", d, 0);
      end else begin
        wait_irq(0, n);
        chk("R5 repeat gap", n, V_EXP[v]);
      end
    end
    wr(8'h20, 0);

    // R7: illegal 11 stored as off
    wr(8'h20, 32'h00C0_00C0);
    rd(8'h20, d); chk("R7 11 reads off", d, 0);
    wr(8'h20, 32'h0080_0040);
    rd(8'h20, d); chk("R7 field positions", d, 32'h0080_0040);
    wr(8'h20, 0);

    // R8: upper free-running, lower control changes around it
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h14, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h20, 32'h0080_0000);
    rd(8'h14, a);
    wr(8'h20, 32'h0080_0040);
    rd(8'h14, b);
    chk("R8 upper undisturbed", b - a, 2);

    // R10: wrap at all ones, R4 direct load
    wr(8'h14, 32'hFFFF_FFFD);
    rd(8'h14, d); chk("R4 load", d, 32'hFFFF_FFFD);
    rd(8'h14, d); chk("R4 step", d, 32'hFFFF_FFFE);
    rd(8'h14, d); chk("R10 top", d, 32'hFFFF_FFFF);
    chk("R10 wrap event", irq_hi, 1);
    rd(8'h14, d); chk("R10 wrapped", d, 0);
    chk("R5 single pulse", irq_hi, 0);

    // R9: zero control stops both
    wr(8'h20, 0);
    rd(8'h14, a);
    rd(8'h10, b);
    repeat (6) @(posedge clk);
    rd(8'h14, d); chk("R9 upper held", d, a);
    rd(8'h10, d); chk("R9 lower held", d, b);

    // R12: unmapped offsets
    wr(8'h30, 32'hDEAD_BEEF);
    rd(8'h30, d); chk("R12 read zero", d, 0);
    rd(8'h20, d); chk("R12 ctrl untouched", d, 0);
    rd(8'h24, d); chk("R12 gctrl untouched", d, 7);

    // R11: compare event from live count plus delta 20
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 0);
    wr(8'h20, 32'h40 << 1);
    rd(8'h10, d);
    wr(8'h60, d + 20);
    wait_irq(0, n);
    chk("R11 compare timing", n, 19);
    quiet(0, 40, "R11 fires once");
    rd(8'h60, a); chk("R11 readback", a, d + 20);

    finish_run();
  end
endmodule